// File: doc/BRIEF.md
# Big-Endian Load/Store Unit

This block carries out the data-memory side of four memory operations: word load, word store, byte load and byte store. For each accepted request it adds a sign-extended 16-bit offset to a 32-bit base value, which gives the effective address. It then drives a word-wide memory port that has four byte-enable lines. For loads it returns the value that the register file should write back. Byte lanes inside a word are big-endian: the byte at the lowest address is the most significant one.

Requests arrive on a valid/ready interface. `req_ready` is low during reset and high at all other times. A request is accepted in any cycle where `req_valid` and `req_ready` are both high, so the unit takes one request per cycle and never applies back-pressure. The memory request is issued in the cycle the request is accepted. The memory returns read data one cycle later, and the load result appears in that same cycle with a one-cycle `rsp_valid` strobe. Results are not buffered, so the consumer must take them in that cycle. A word access whose effective address is not a multiple of four never reaches memory; the unit raises `misalign_err` for one cycle in its place.

Top module: `bytelane_lsu`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, with wrap-around, so negative offsets work. `mem_addr` carries bits 31:2 of it. Operation codes on `req_op` are 00 word load, 01 word store, 10 byte load and 11 byte store.
- R2: A word load returns the memory word unchanged. Byte offset 0 sits in bits 31:24 and offset 3 in bits 7:0, so bytes 00,00,02,01 at addresses 0..3 load as 0x00000201.
- R3: A word store drives `mem_be` = 4'b1111 and `mem_wdata` equal to the source value, using the same lane mapping as a word load.
- R4: A byte load returns the addressed byte in bits 7:0 with bits 31:8 forced to zero. Byte offset k is taken from bits 31-8k down to 24-8k.
- R5: A byte store raises only `mem_be[3-k]` for byte offset k and places bits 7:0 of the source in that lane. The other three bytes of the memory word keep their contents.
- R6: Byte loads and stores are legal at any address and never raise `misalign_err`.
- R7: A word access whose effective address has nonzero bits 1:0 drives no memory request and no write. In the following cycle it raises `misalign_err` for that cycle and produces no `rsp_valid`, so nothing is written back.
- R8: Every accepted legal load raises `rsp_valid` in exactly the next cycle, together with its data. Stores never raise `rsp_valid`.
- R9: During reset `req_ready`, `mem_req`, `rsp_valid` and `misalign_err` are low. After reset `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_op | input | 2 | Operation code |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed address offset |
| req_wdata | input | 32 | Store source register value |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_addr | output | 30 | Word address (effective address bits 31:2) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read request |
| rsp_valid | output | 1 | Load result strobe |
| rsp_data | output | 32 | Load result for write-back |
| misalign_err | output | 1 | One-cycle misaligned word access flag |

## Verification
A word is first stored with four distinct bytes, for example 0xA1B2C3D4. Reading that word back at every byte offset then separates big-endian lane selection from little-endian selection. The high bit of byte 0xA1 also separates zero extension from sign extension. Positive, zero and negative offsets check that the offset is sign-extended when the address is formed. A byte store of 0x5E into one lane, followed by a word read, shows that only that lane changed. Misaligned word loads and stores, followed by reads of the target word, show that nothing reached memory and that the error replaces the result.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    OP_LDW = 2'b00,
    OP_STW = 2'b01,
    OP_LDB = 2'b10,
    OP_STB = 2'b11
  } lsu_op_e;

  function automatic logic op_is_store(lsu_op_e op);
    return op[0];
  endfunction

  function automatic logic op_is_byte(lsu_op_e op);
    return op[1];
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0]        base,
  input  logic [OFF_W-1:0]         offset,
  input  logic                     is_word,
  output logic [ADDR_W-LANE_W-1:0] word_addr,
  output logic [LANE_W-1:0]        lane,
  output logic                     misaligned
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] ea;

  always_comb begin
    ea         = base + {{EXT_W{offset[OFF_W-1]}}, offset};
    word_addr  = ea[ADDR_W-1:LANE_W];
    lane       = ea[LANE_W-1:0];
    misaligned = is_word && (lane != '0);
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  logic [DATA_W-1:0]   src,
  input  logic [LANE_W-1:0]   lane,
  input  logic                is_byte,
  output logic [DATA_W/8-1:0] be,
  output logic [DATA_W-1:0]   wdata
);
  localparam int BYTES = DATA_W / 8;

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    // big-endian: lowest byte offset drives the most significant lane
    localparam logic [LANE_W-1:0] SEL = LANE_W'(BYTES - 1 - i);
    assign be[i]          = is_byte ? (lane == SEL) : 1'b1;
    assign wdata[8*i +: 8] = is_byte ? src[7:0] : src[8*i +: 8];
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [LANE_W-1:0] lane,
  input  logic              is_byte,
  output logic [DATA_W-1:0] result
);
  localparam int BYTES = DATA_W / 8;

  logic [7:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (lane == LANE_W'(BYTES - 1 - i)) pick = rdata[8*i +: 8];
    end
    result = is_byte ? {{(DATA_W-8){1'b0}}, pick} : rdata;
  end
endmodule

// File: rtl/bytelane_lsu.sv
module bytelane_lsu #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 32,
  localparam int BYTES   = DATA_W / 8,
  localparam int LANE_W  = $clog2(BYTES),
  localparam int WADDR_W = ADDR_W - LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [ADDR_W-1:0]  req_base,
  input  logic [OFF_W-1:0]   req_offset,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [BYTES-1:0]   mem_be,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               misalign_err
);
  import lsu_pkg::*;

  lsu_op_e           op;
  logic              accept, is_byte, is_store, misaligned;
  logic [LANE_W-1:0] lane;
  logic              rdy_q, ld_pend_q, ld_byte_q, err_q;
  logic [LANE_W-1:0] ld_lane_q;
  logic [BYTES-1:0]  be_raw;

  assign op       = lsu_op_e'(req_op);
  assign is_byte  = op_is_byte(op);
  assign is_store = op_is_store(op);
  assign accept   = req_valid && rdy_q;

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) agen_i (
    .base(req_base), .offset(req_offset), .is_word(!is_byte),
    .word_addr(mem_addr), .lane(lane), .misaligned(misaligned)
  );

  lsu_store_steer #(.DATA_W(DATA_W), .LANE_W(LANE_W)) steer_i (
    .src(req_wdata), .lane(lane), .is_byte(is_byte),
    .be(be_raw), .wdata(mem_wdata)
  );

  lsu_load_extract #(.DATA_W(DATA_W), .LANE_W(LANE_W)) extract_i (
    .rdata(mem_rdata), .lane(ld_lane_q), .is_byte(ld_byte_q),
    .result(rsp_data)
  );

  assign mem_req      = accept && !misaligned;
  assign mem_we       = mem_req && is_store;
  assign mem_be       = mem_req ? be_raw : '0;
  assign req_ready    = rdy_q;
  assign rsp_valid    = ld_pend_q;
  assign misalign_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q     <= 1'b0;
      ld_pend_q <= 1'b0;
      ld_byte_q <= 1'b0;
      ld_lane_q <= '0;
      err_q     <= 1'b0;
    end else begin
      rdy_q     <= 1'b1;
      ld_pend_q <= mem_req && !is_store;
      err_q     <= accept && misaligned;
      if (mem_req && !is_store) begin
        ld_byte_q <= is_byte;
        ld_lane_q <= lane;
      end
    end
  end
endmodule

// File: rtl/bytelane_lsu_checker.sv
module bytelane_lsu_checker #(
  parameter int DATA_W = 32,
  parameter int BYTES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [1:0]        base_lo,
  input logic [1:0]        off_lo,
  input logic              mem_req,
  input logic              mem_we,
  input logic [BYTES-1:0]  mem_be,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              misalign_err
);
  logic       acc, bad_word;
  logic [1:0] ea_lo;
  assign acc      = req_valid && req_ready;
  assign ea_lo    = base_lo + off_lo;
  assign bad_word = acc && !req_op[1] && (ea_lo != 2'b00);

  assert_no_mem_on_misalign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_word |-> !mem_req && !mem_we);
  assert_err_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_word |=> misalign_err && !rsp_valid);
  assert_byte_no_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op[1]) |=> !misalign_err);
  assert_load_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_op[0] && !bad_word) |=> rsp_valid);
  assert_store_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op[0]) |=> !rsp_valid);
  assert_byte_zext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'b10) |=> rsp_data[DATA_W-1:8] == '0);
  assert_byte_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_op == 2'b11) |-> mem_we && $countones(mem_be) == 1);
  assert_word_all_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_op == 2'b01) |-> mem_we && mem_be == '1);
endmodule

bind bytelane_lsu bytelane_lsu_checker #(.DATA_W(DATA_W), .BYTES(BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .base_lo(req_base[1:0]), .off_lo(req_offset[1:0]),
  .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .misalign_err(misalign_err)
);

// File: tb/bytelane_lsu_tb_top.sv
`timescale 1ns/1ps
module bytelane_lsu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_req, mem_we;
  logic [3:0]  mem_be;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, misalign_err;
  logic [31:0] rsp_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [31:0] mem [16];

  // captured port values of the last operation
  logic        c_req, c_we, c_valid, c_err;
  logic [3:0]  c_be;
  logic [29:0] c_addr;
  logic [31:0] c_wdata, c_data;

  always #2.5 clk = ~clk;

  bytelane_lsu dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_base(req_base), .req_offset(req_offset),
    .req_wdata(req_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .misalign_err(misalign_err)
  );

  // memory model: one-cycle read latency, byte-enabled writes
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[3:0]];
      end
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected < 20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [31:0] base,
                       input logic [15:0] off, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = base; req_offset = off; req_wdata = wd;
    #1;
    c_req = mem_req; c_we = mem_we; c_be = mem_be; c_addr = mem_addr; c_wdata = mem_wdata;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    c_valid = rsp_valid; c_err = misalign_err; c_data = rsp_data;
  endtask

  task automatic t_reset;
    #1;
    check("R9 ready low in reset", 32'(req_ready), 32'd0);
    check("R9 rsp_valid low in reset", 32'(rsp_valid), 32'd0);
    check("R9 err low in reset", 32'(misalign_err), 32'd0);
    check("R9 mem_req low in reset", 32'(mem_req), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready high after reset", 32'(req_ready), 32'd1);
  endtask

  task automatic t_word_store;
    do_op(2'b01, 32'd12, 16'd0, 32'hA1B2C3D4);
    check("R3 word store be", 32'(c_be), 32'hF);
    check("R3 word store wdata", c_wdata, 32'hA1B2C3D4);
    check("R3 word store we", 32'(c_we), 32'd1);
    check("R8 store gives no rsp_valid", 32'(c_valid), 32'd0);
    do_op(2'b00, 32'd12, 16'd0, '0);
    check("R3 word store read back", c_data, 32'hA1B2C3D4);
  endtask

  task automatic t_word_load;
    do_op(2'b00, 32'd0, 16'd0, '0);
    check("R8 load strobe", 32'(c_valid), 32'd1);
    check("R2 big-endian word at 0", c_data, 32'h00000201);
    do_op(2'b00, 32'd4, 16'd4, '0);
    check("R1 positive offset addr", 32'(c_addr), 32'd2);
    check("R1 positive offset data", c_data, 32'h00000101);
    do_op(2'b00, 32'd4, 16'hFFFC, '0);
    check("R1 negative offset addr", 32'(c_addr), 32'd0);
    check("R1 negative offset data", c_data, 32'h00000201);
  endtask

  task automatic t_byte_load;
    do_op(2'b10, 32'd3, 16'd0, '0);
    check("R4 byte offset 3 of 00000201", c_data, 32'h00000001);
    do_op(2'b10, 32'd2, 16'd0, '0);
    check("R4 byte offset 2 of 00000201", c_data, 32'h00000002);
    do_op(2'b10, 32'd12, 16'd0, '0);
    check("R4 byte offset 0 zero-extended", c_data, 32'h000000A1);
    do_op(2'b10, 32'd13, 16'd0, '0);
    check("R4 byte offset 1", c_data, 32'h000000B2);
    check("R6 odd byte load no error", 32'(c_err), 32'd0);
    do_op(2'b10, 32'd20, 16'hFFFB, '0);
    check("R4 byte offset 3 via negative offset", c_data, 32'h000000D4);
  endtask

  task automatic t_byte_store;
    do_op(2'b11, 32'd14, 16'd0, 32'hFFFFFF5E);
    check("R5 byte store single lane", 32'(c_be), 32'h2);
    check("R6 byte store no error", 32'(c_err), 32'd0);
    do_op(2'b00, 32'd12, 16'd0, '0);
    check("R5 byte store merges lane", c_data, 32'hA1B25ED4);
  endtask

  task automatic t_misaligned;
    do_op(2'b00, 32'd12, 16'd2, '0);
    check("R7 misaligned load no mem_req", 32'(c_req), 32'd0);
    check("R7 misaligned load err", 32'(c_err), 32'd1);
    check("R7 misaligned load no rsp_valid", 32'(c_valid), 32'd0);
    do_op(2'b01, 32'd13, 16'd0, 32'h00000000);
    check("R7 misaligned store no write", 32'(c_we), 32'd0);
    check("R7 misaligned store err", 32'(c_err), 32'd1);
    do_op(2'b00, 32'd12, 16'd0, '0);
    check("R7 word untouched after misaligned store", c_data, 32'hA1B25ED4);
    check("R7 err cleared after aligned op", 32'(c_err), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem[0] = 32'h00000201;
    mem[1] = 32'h00000204;
    mem[2] = 32'h00000101;
    repeat (3) @(posedge clk);
    t_reset();
    t_word_load();
    t_word_store();
    t_byte_load();
    t_byte_store();
    t_misaligned();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule